// File: doc/BRIEF.md
# Sequential Field Memory Channel

This block is one channel of a sequential field memory. Words of `WORD_W` bits are stored at a write address counter and returned from a separate read address counter. No flags and no handshake govern the counters. Each side has its own clock, a synchronous reset pulse that returns its counter to word 0, and an active-low enable that advances it. Both counters wrap silently at the end of the array, so old words are overwritten without notice.

The usual application is a fixed delay line, and there are two ways to set it up. In the first, both enables stay active and read reset is pulsed N read cycles after write reset. In the second, both resets are pulsed together and read enable is held off for N cycles, which keeps the read address frozen while writing continues.

The read data output is registered. It is paired with a drive flag that models a three-state bus: the flag is low in the cycle after an edge where read was disabled, and the data lines then read zero.

The output stage is a two-state machine clocked by `rd_clk`. State OUT_FLOAT means the bus is released. State OUT_DRIVE means a word is presented. On each edge the machine takes FLOAT→DRIVE, or stays in DRIVE, when `rd_en_n` is low. It takes DRIVE→FLOAT, or stays in FLOAT, when `rd_en_n` is high.

Top module: `fmc_channel`

## Requirements
- R1: Each word keeps all `WORD_W` bits (default 4), and `DEPTH` words are stored (default 1024). A stored word reads back unchanged.
- R2: On a `wr_clk` edge where `wr_rst` is high, the write address becomes 0 and no word is stored, even when `wr_en_n` is low.
- R3: On a `wr_clk` edge where `wr_rst` is low and `wr_en_n` is low, `wr_data` is stored at the write address and the address steps by one. When `wr_en_n` is high, nothing is stored and the address holds.
- R4: On a `rd_clk` edge where `rd_rst` is high, the read address becomes 0 and no word is transferred. `q_data` keeps its previous word.
- R5: On a `rd_clk` edge where `rd_rst` is low and `rd_en_n` is low, the word at the read address appears on `q_data` after that edge, and the read address steps by one. When `rd_en_n` is high, the read address holds.
- R6: Both address counters wrap from `DEPTH-1` to 0. A later write to a wrapped address replaces the old word.
- R7: `q_drive` is 1 after a `rd_clk` edge that samples `rd_en_n` low, and 0 after an edge that samples it high. While `q_drive` is 0, `q_data` is all zeros.
- R8: When the read and write sides hit the same address on a shared clock edge, the read returns the word held before that edge's write.
- R9: With both enables held low and `rd_rst` pulsed N cycles after `wr_rst`, the word written k cycles after the write reset appears N cycles later.
- R10: With both resets pulsed together and `rd_en_n` held high for the next N cycles, the output is the written stream delayed by exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write side clock |
| wr_rst | input | 1 | Synchronous write address reset, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WORD_W | Word to store |
| rd_clk | input | 1 | Read side clock |
| rd_rst | input | 1 | Synchronous read address reset, active high |
| rd_en_n | input | 1 | Read enable, active low |
| q_data | output | WORD_W | Registered read word, zeros while released |
| q_drive | output | 1 | Bus drive flag, high while a word is presented |

## Verification
Two things can fall on the same edge. The first is a reset together with an active enable on the same side, where the reset must win and nothing may be stored or transferred. The second is a write and a read to the same address, where the read must return the older word. Directed sequences place each collision deliberately: a reset edge with enable low, followed by a readback of address 0, and simultaneous resets followed by a read and a write on the next edge. A seeded random phase then raises resets and enables freely on a shared clock. A bench reference memory predicts every output word and drive flag, and both are compared after each edge.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
    typedef enum logic {
        OUT_FLOAT = 1'b0,
        OUT_DRIVE = 1'b1
    } fmc_out_e;
endpackage

// File: rtl/fmc_addr_ctr.sv
module fmc_addr_ctr #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          adv_n,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (clr) begin
            addr <= '0;
        end else if (!adv_n) begin
            if (addr == LAST) begin
                addr <= '0;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fmc_store.sv
module fmc_store #(
    parameter int WORD_W = 4,
    parameter int DEPTH  = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              wen,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rclk,
    input  logic              ren,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (wen) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (ren) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/fmc_channel.sv
module fmc_channel
    import fmc_pkg::*;
#(
    parameter int WORD_W = 4,
    parameter int DEPTH  = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en_n,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en_n,
    output logic [WORD_W-1:0] q_data,
    output logic              q_drive
);
    logic [AW-1:0]     w_addr;
    logic [AW-1:0]     r_addr;
    logic [WORD_W-1:0] r_word;
    logic              w_take;
    logic              r_take;
    fmc_out_e          out_st;
    fmc_out_e          out_nx;

    assign w_take = !wr_rst && !wr_en_n;
    assign r_take = !rd_rst && !rd_en_n;

    fmc_addr_ctr #(.DEPTH(DEPTH)) i_wctr (
        .clk   (wr_clk),
        .clr   (wr_rst),
        .adv_n (wr_en_n),
        .addr  (w_addr)
    );

    fmc_addr_ctr #(.DEPTH(DEPTH)) i_rctr (
        .clk   (rd_clk),
        .clr   (rd_rst),
        .adv_n (rd_en_n),
        .addr  (r_addr)
    );

    fmc_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_store (
        .wclk  (wr_clk),
        .wen   (w_take),
        .waddr (w_addr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .ren   (r_take),
        .raddr (r_addr),
        .rdata (r_word)
    );

    always_comb begin
        unique case (out_st)
            OUT_FLOAT: out_nx = rd_en_n ? OUT_FLOAT : OUT_DRIVE;
            OUT_DRIVE: out_nx = rd_en_n ? OUT_FLOAT : OUT_DRIVE;
            default:   out_nx = OUT_FLOAT;
        endcase
    end

    always_ff @(posedge rd_clk) begin
        out_st <= out_nx;
    end

    always_comb begin
        unique case (out_st)
            OUT_DRIVE: begin
                q_drive = 1'b1;
                q_data  = r_word;
            end
            default: begin
                q_drive = 1'b0;
                q_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/fmc_channel_chk.sv
module fmc_channel_chk #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_en_n,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en_n,
    input logic [AW-1:0] w_addr,
    input logic [AW-1:0] r_addr,
    input logic          q_drive
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    logic w_armed = 1'b0;
    logic r_armed = 1'b0;
    logic r_ticked = 1'b0;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) w_armed <= 1'b1;
    end

    always_ff @(posedge rd_clk) begin
        r_ticked <= 1'b1;
        if (rd_rst) r_armed <= 1'b1;
    end

    // R2
    wr_reset_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        wr_rst |=> (w_addr == '0));

    // R3
    wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        (!wr_rst && wr_en_n) |=> $stable(w_addr));

    // R3
    wr_step_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        (!wr_rst && !wr_en_n && w_addr != LAST) |=> (w_addr == $past(w_addr) + 1'b1));

    // R6
    wr_wrap_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        (!wr_rst && !wr_en_n && w_addr == LAST) |=> (w_addr == '0));

    // R4
    rd_reset_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        rd_rst |=> (r_addr == '0));

    // R5
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        (!rd_rst && rd_en_n) |=> $stable(r_addr));

    // R6
    rd_wrap_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        (!rd_rst && !rd_en_n && r_addr == LAST) |=> (r_addr == '0));

    // R7
    drive_off_chk: assert property (@(posedge rd_clk) disable iff (!r_ticked)
        rd_en_n |=> !q_drive);

    // R7
    drive_on_chk: assert property (@(posedge rd_clk) disable iff (!r_ticked)
        !rd_en_n |=> q_drive);
endmodule

bind fmc_channel fmc_channel_chk #(.DEPTH(DEPTH)) i_fmc_chk (
    .wr_clk  (wr_clk),
    .wr_rst  (wr_rst),
    .wr_en_n (wr_en_n),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .rd_en_n (rd_en_n),
    .w_addr  (w_addr),
    .r_addr  (r_addr),
    .q_drive (q_drive)
);

// File: tb/test_fmc_channel.sv
module test_fmc_channel;
    localparam int W = 4;
    localparam int D = 64;

    logic         clk = 1'b0;
    logic         wrst = 1'b0, wen_n = 1'b1, rrst = 1'b0, ren_n = 1'b1;
    logic [W-1:0] wd = '0;
    logic [W-1:0] qd;
    logic         qv;
    int total = 0;
    int bad = 0;

    logic [W-1:0] mem [D];
    int           mw = 0, mr = 0;
    logic [W-1:0] mq;
    logic         mv = 1'b0;
    logic [W-1:0] hist [80];

    always #2 clk = ~clk;

    fmc_channel #(.WORD_W(W), .DEPTH(D)) i_fmc_channel (
        .wr_clk (clk), .wr_rst (wrst), .wr_en_n (wen_n), .wr_data (wd),
        .rd_clk (clk), .rd_rst (rrst), .rd_en_n (ren_n),
        .q_data (qd), .q_drive (qv)
    );

    function automatic logic [W-1:0] exp_q(input logic v, input logic [W-1:0] q);
        return v ? q : '0;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic we, input logic [W-1:0] d,
                       input logic rr, input logic re);
        @(negedge clk);
        wrst = wr; wen_n = we; wd = d; rrst = rr; ren_n = re;
        @(posedge clk);
        if (rr) mr = 0;
        else if (!re) begin mq = mem[mr]; mr = (mr + 1) % D; end
        mv = !re;
        if (wr) mw = 0;
        else if (!we) begin mem[mw] = d; mw = (mw + 1) % D; end
        #1;
        check("R7 drive", {3'b0, qv}, {3'b0, mv});
        check("R5 data", qd, exp_q(mv, mq));
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [W-1:0] held;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 80; i++) hist[i] = W'($urandom);

        // reset state: R7 released bus reads zero
        cyc(1, 1, 0, 1, 1);
        check("R7 reset", {3'b0, qv}, 4'h0);

        // R9: read reset N=20 cycles after write reset
        for (int s = 0; s <= 50; s++) begin
            cyc(s == 0, 0, (s >= 1) ? hist[s-1] : 4'h0, s == 20, (s >= 20) ? 1'b0 : 1'b1);
            if (s >= 21) check("R9 delay", qd, hist[s-21]);
        end

        // R10: joint reset, read held off for N=37 cycles
        for (int s = 0; s <= 60; s++) begin
            cyc(s == 0, 0, (s >= 1) ? hist[s-1] : 4'h0, s == 0, (s > 37) ? 1'b0 : 1'b1);
            if (s >= 38) check("R10 delay", qd, hist[s-38]);
        end

        // R6: write 70 words into 64 cells, then read around the ring
        for (int s = 0; s <= 70; s++)
            cyc(s == 0, (s >= 1) ? 1'b0 : 1'b1, (s >= 1) ? hist[s-1] : 4'h0, s == 0, 1);
        for (int j = 0; j <= 64; j++) begin
            cyc(0, 1, 0, 0, 0);
            if (j == 0)  check("R6 overwrite", qd, hist[64]);
            if (j == 6)  check("R6 old word", qd, hist[6]);
            if (j == 64) check("R6 read wrap", qd, hist[64]);
        end

        // R8: same address on the same edge returns the older word
        cyc(1, 1, 0, 1, 1);
        cyc(0, 0, 4'hA, 0, 0);
        check("R8 old word", qd, hist[64]);
        cyc(0, 1, 0, 1, 1);
        cyc(0, 1, 0, 0, 0);
        check("R8 new word", qd, 4'hA);

        // R4: read reset with enable low keeps output word
        cyc(0, 1, 0, 0, 0);
        held = qd;
        cyc(0, 1, 0, 1, 0);
        check("R4 hold", qd, held);
        check("R4 drive", {3'b0, qv}, 4'h1);
        cyc(0, 1, 0, 0, 0);
        check("R4 addr0", qd, 4'hA);

        // R2: reset wins over write enable
        cyc(1, 0, 4'h5, 1, 1);
        cyc(0, 0, 4'h6, 0, 1);
        cyc(0, 1, 0, 1, 1);
        cyc(0, 1, 0, 0, 0);
        check("R2 reset wins", qd, 4'h6);

        // R3: disabled write stores nothing
        cyc(1, 1, 0, 1, 1);
        cyc(0, 1, 4'h9, 0, 1);
        cyc(0, 0, 4'h3, 0, 1);
        cyc(0, 1, 0, 0, 0);
        check("R3 skip", qd, 4'h3);

        // R1: random traffic, every word against reference memory
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] dv;
            dv = W'($urandom);
            cyc(($urandom % 40) == 0, ($urandom % 4) == 0, dv,
                ($urandom % 40) == 0, ($urandom % 3) == 0);
        end
        check("R1 final", qd, exp_q(mv, mq));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule